// File: doc/BRIEF.md
# Receive FIFO Index and Fill Tracker

This block keeps the bookkeeping for one 64-slot message receive FIFO. The message storage itself is elsewhere. The frame receiver pulses a strobe each time it has finished storing a message, and that strobe is a push. The host pops the oldest message by writing a register word with the pop command bit set. The command bit is not stored; it acts only on the cycle of the write. The block tracks the slot the host should read next, the slot the receiver fills next, and how many messages are held. It also presents the byte address where the next message to read starts, plus a status word for register readback.

Both inputs are single-cycle strobes with no back-pressure. A pop on an empty FIFO is ignored. A push on a full FIFO is dropped, and a one-cycle overflow pulse reports it. There is no ready signal at either side. For two independent FIFOs, place two instances.

Top module: `rxf_index_tracker`

## Requirements
- R1: The read index is 6 bits wide. Popping at index 63 moves it to 0.
- R2: The fill level never exceeds 64 and never goes below 0.
- R3: A host write with bit 7 of the write data at 1, while the fill level is above 0, raises the read index by one and lowers the fill level by one. Both changes are visible after the next rising clock edge. A write with bit 7 at 0 changes nothing, and the other data bits are ignored.
- R4: A pop command while the fill level is 0 leaves the read index unchanged and does not lower the fill level.
- R5: The status word carries the fill level in bits 14:8 and the read index in bits 21:16. Bit 7 and every other bit always read 0.
- R6: A pop and a push accepted in the same cycle leave the fill level unchanged, and both indices advance.
- R7: The next-read address equals 0x4100 + read index × 0x48, for example 0x4190 at index 2. It follows the read index with no extra delay.
- R8: While core enable is low, pushes and pop commands are ignored, and the indices and fill level hold their values.
- R9: A synchronous soft reset, or the asynchronous active-low hard reset, returns the read index, write index, fill level and overflow pulse to 0.
- R10: A push while the fill level is 64 and no pop is accepted in the same cycle is dropped. The write index does not move, and the overflow output is high for exactly the following cycle.
- R11: An accepted push raises the write index by one, wrapping from 63 to 0, and raises the fill level by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous active-high soft reset |
| core_en | input | 1 | Core enable; low freezes all state |
| host_wr_en | input | 1 | Host write strobe to the status register |
| host_wr_data | input | 32 | Host write data; bit 7 is the pop command |
| rx_done | input | 1 | Receive-complete strobe (push) |
| rd_idx | output | 6 | Slot the host reads next |
| wr_idx | output | 6 | Slot the receiver fills next |
| fill_lvl | output | 7 | Number of stored messages |
| next_addr | output | 16 | Byte start address of the slot at the read index |
| status_rdata | output | 32 | Status register readback |
| ovf_pulse | output | 1 | One-cycle pulse after a dropped push |

## Verification
Every index, fill level and overflow result is registered, so each one is due one rising edge after the push, pop or reset that causes it. The address and status word are combinational on those registers and are due in the same cycle. The bench drives inputs two nanoseconds after a rising edge and compares every output with its own model at the falling edge. Directed checks read outputs right after the edge that should have applied the stimulus. The hard reset is asynchronous, so its effect is checked at the first falling edge after it is asserted.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  // bit positions in the status readback word
  localparam int unsigned ST_CMD_BIT  = 7;
  localparam int unsigned ST_FILL_LSB = 8;
  localparam int unsigned ST_IDX_LSB  = 16;

  // fill level action for one cycle
  typedef enum logic [1:0] {
    FILL_HOLD = 2'd0,
    FILL_UP   = 2'd1,
    FILL_DOWN = 2'd2,
    FILL_CLR  = 2'd3
  } fill_op_e;
endpackage

// File: rtl/rxf_wrap_ctr.sv
module rxf_wrap_ctr #(
  parameter int unsigned W     = 6,
  parameter int unsigned LIMIT = 64
) (
  input  logic         clk,
  input  logic         hard_rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n)  q <= '0;
    else if (clr)     q <= '0;
    else if (inc)     q <= (q == LAST) ? '0 : q + 1'b1;
  end

  // R1 / R11: a wrapping counter only ever steps by one or returns to 0
  assert_wrap_step_R1: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (inc && !clr && q == LAST) |=> (q == '0));
endmodule

// File: rtl/rxf_fill_ctr.sv
module rxf_fill_ctr
  import rxf_pkg::*;
#(
  parameter int unsigned W     = 7,
  parameter int unsigned LIMIT = 64
) (
  input  logic         clk,
  input  logic         hard_rst_n,
  input  fill_op_e     op,
  output logic [W-1:0] q,
  output logic         empty,
  output logic         full
);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) q <= '0;
    else begin
      unique case (op)
        FILL_UP:   q <= q + 1'b1;
        FILL_DOWN: q <= q - 1'b1;
        FILL_CLR:  q <= '0;
        default:   q <= q;
      endcase
    end
  end

  assign empty = (q == '0);
  assign full  = (q == TOP);

  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!hard_rst_n)
    q <= TOP);
  assert_no_up_when_full_R10: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (op == FILL_UP) |-> (q != TOP));
  assert_no_down_when_empty_R4: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (op == FILL_DOWN) |-> (q != '0));
endmodule

// File: rtl/rxf_slot_addr.sv
module rxf_slot_addr #(
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned BASE_ADDR  = 32'h4100,
  parameter int unsigned SLOT_BYTES = 72
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] BASE   = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(SLOT_BYTES);

  logic [ADDR_W-1:0] offs;

  always_comb begin
    offs = ADDR_W'(idx) * STRIDE;
    addr = BASE + offs;
  end
endmodule

// File: rtl/rxf_index_tracker.sv
module rxf_index_tracker
  import rxf_pkg::*;
#(
  parameter int unsigned SLOTS      = 64,
  parameter int unsigned BASE_ADDR  = 32'h4100,
  parameter int unsigned SLOT_BYTES = 72,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 32
) (
  input  logic              clk,
  input  logic              hard_rst_n,
  input  logic              soft_rst,
  input  logic              core_en,
  input  logic              host_wr_en,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              rx_done,
  output logic [$clog2(SLOTS)-1:0]   rd_idx,
  output logic [$clog2(SLOTS)-1:0]   wr_idx,
  output logic [$clog2(SLOTS+1)-1:0] fill_lvl,
  output logic [ADDR_W-1:0]          next_addr,
  output logic [DATA_W-1:0]          status_rdata,
  output logic                       ovf_pulse
);
  localparam int unsigned IDX_W  = $clog2(SLOTS);
  localparam int unsigned FILL_W = $clog2(SLOTS + 1);

  logic pop_req, push_req, pop_ok, push_ok;
  logic is_empty, is_full;
  fill_op_e fill_op;
  logic unused_wr_bits;

  assign unused_wr_bits = ^host_wr_data;

  // command decode and acceptance
  assign pop_req  = core_en && host_wr_en && host_wr_data[ST_CMD_BIT];
  assign push_req = core_en && rx_done;
  assign pop_ok   = pop_req && !is_empty && !soft_rst;
  assign push_ok  = push_req && (!is_full || pop_ok) && !soft_rst;

  always_comb begin
    if (soft_rst)                fill_op = FILL_CLR;
    else if (push_ok && !pop_ok) fill_op = FILL_UP;
    else if (pop_ok && !push_ok) fill_op = FILL_DOWN;
    else                         fill_op = FILL_HOLD;
  end

  rxf_wrap_ctr #(.W(IDX_W), .LIMIT(SLOTS)) u_rd_ctr (
    .clk(clk), .hard_rst_n(hard_rst_n), .clr(soft_rst), .inc(pop_ok), .q(rd_idx)
  );

  rxf_wrap_ctr #(.W(IDX_W), .LIMIT(SLOTS)) u_wr_ctr (
    .clk(clk), .hard_rst_n(hard_rst_n), .clr(soft_rst), .inc(push_ok), .q(wr_idx)
  );

  rxf_fill_ctr #(.W(FILL_W), .LIMIT(SLOTS)) u_fill (
    .clk(clk), .hard_rst_n(hard_rst_n), .op(fill_op),
    .q(fill_lvl), .empty(is_empty), .full(is_full)
  );

  rxf_slot_addr #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .SLOT_BYTES(SLOT_BYTES)
  ) u_addr (
    .idx(rd_idx), .addr(next_addr)
  );

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n)   ovf_pulse <= 1'b0;
    else if (soft_rst) ovf_pulse <= 1'b0;
    else               ovf_pulse <= push_req && !push_ok;
  end

  // status readback: the command bit is never stored and reads 0
  always_comb begin
    status_rdata = '0;
    status_rdata[ST_FILL_LSB +: FILL_W] = fill_lvl;
    status_rdata[ST_IDX_LSB  +: IDX_W]  = rd_idx;
    status_rdata[ST_CMD_BIT]            = 1'b0;
  end

  assert_pop_empty_R4: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (pop_req && fill_lvl == '0 && !soft_rst) |=> $stable(rd_idx));
  assert_same_cycle_R6: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (pop_req && push_req && fill_lvl != '0 && !soft_rst) |=> $stable(fill_lvl));
  assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (!core_en && !soft_rst) |=> ($stable(rd_idx) && $stable(wr_idx) && $stable(fill_lvl)));
  assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!hard_rst_n)
    soft_rst |=> (rd_idx == '0 && wr_idx == '0 && fill_lvl == '0 && !ovf_pulse));
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!hard_rst_n)
    ovf_pulse |-> ($past(fill_lvl) == FILL_W'(SLOTS) && $stable(wr_idx)));
  assert_index_gap_R11: assert property (@(posedge clk) disable iff (!hard_rst_n)
    IDX_W'(wr_idx - rd_idx) == fill_lvl[IDX_W-1:0]);
endmodule

// File: tb/sim_rxf_index_tracker.sv
`timescale 1ns/1ps
module sim_rxf_index_tracker;
  logic        clk = 1'b0;
  logic        hard_rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        core_en = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [31:0] host_wr_data = '0;
  logic        rx_done = 1'b0;
  logic [5:0]  rd_idx, wr_idx;
  logic [6:0]  fill_lvl;
  logic [15:0] next_addr;
  logic [31:0] status_rdata;
  logic        ovf_pulse;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int m_rd = 0, m_wr = 0, m_fill = 0, m_ovf = 0;
  bit compare_on = 1'b0;

  always #4 clk = ~clk;

  rxf_index_tracker u0 (
    .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst(soft_rst), .core_en(core_en),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data), .rx_done(rx_done),
    .rd_idx(rd_idx), .wr_idx(wr_idx), .fill_lvl(fill_lvl), .next_addr(next_addr),
    .status_rdata(status_rdata), .ovf_pulse(ovf_pulse)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model: one update per rising edge, reset is asynchronous
  always @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      m_rd = 0; m_wr = 0; m_fill = 0; m_ovf = 0;
    end else if (soft_rst) begin
      m_rd = 0; m_wr = 0; m_fill = 0; m_ovf = 0;
    end else begin
      bit pop, push, pop_ok, push_ok;
      pop     = core_en && host_wr_en && host_wr_data[7];
      push    = core_en && rx_done;
      pop_ok  = pop && m_fill > 0;
      push_ok = push && (m_fill < 64 || pop_ok);
      if (pop_ok)  begin m_rd = (m_rd + 1) % 64; m_fill = m_fill - 1; end
      if (push_ok) begin m_wr = (m_wr + 1) % 64; m_fill = m_fill + 1; end
      m_ovf = (push && !push_ok) ? 1 : 0;
    end
  end

  // compare everything every cycle, away from the rising edge
  always @(negedge clk) begin
    if (compare_on) begin
      check("R3 rd_idx", rd_idx, m_rd);
      check("R11 wr_idx", wr_idx, m_wr);
      check("R2 fill_lvl", fill_lvl, m_fill);
      check("R7 next_addr", next_addr, 'h4100 + m_rd * 'h48);
      check("R5 status", status_rdata, (m_fill << 8) | (m_rd << 16));
      check("R10 ovf_pulse", ovf_pulse, m_ovf);
    end
  end

  // drive for one rising edge; returns 2 ns after that edge
  task automatic drive(input bit en, input bit wr, input logic [31:0] d, input bit push);
    core_en = en; host_wr_en = wr; host_wr_data = d; rx_done = push;
    @(posedge clk); #2;
    host_wr_en = 1'b0; rx_done = 1'b0;
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) drive(1, 0, 32'h0, 1);
  endtask

  task automatic pop_n(input int n);
    for (int i = 0; i < n; i++) drive(1, 1, 32'h0000_0080, 0);
  endtask

  initial begin
    #1_600_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(posedge clk); #2;
    compare_on = 1'b1;
    @(posedge clk); #2;
    // R9: state after hard reset
    check("R9 reset rd_idx", rd_idx, 0);
    check("R9 reset fill", fill_lvl, 0);
    check("R9 reset ovf", ovf_pulse, 0);
    hard_rst_n = 1'b1;
    core_en = 1'b1;

    push_n(5);
    check("R11 wr after 5 pushes", wr_idx, 5);
    check("R11 fill after 5 pushes", fill_lvl, 5);

    drive(1, 1, 32'hFFFF_FFFF, 0);
    drive(1, 1, 32'h0000_0080, 0);
    check("R3 rd after 2 pops", rd_idx, 2);
    check("R3 fill after 2 pops", fill_lvl, 3);
    check("R7 addr at index 2", next_addr, 'h4190);
    check("R5 status word", status_rdata, 32'h0002_0300);

    drive(1, 1, 32'hFFFF_FF7F, 0);
    check("R3 bit7 low no pop", rd_idx, 2);

    pop_n(3);
    check("R3 drained fill", fill_lvl, 0);
    drive(1, 1, 32'h0000_0080, 0);
    check("R4 empty pop rd", rd_idx, 5);
    check("R4 empty pop fill", fill_lvl, 0);

    drive(1, 1, 32'h0000_0080, 1);
    check("R6 both at empty fill", fill_lvl, 1);
    drive(1, 1, 32'h0000_0080, 1);
    check("R6 both fill", fill_lvl, 1);
    check("R6 both rd", rd_idx, 6);
    check("R6 both wr", wr_idx, 7);

    drive(0, 1, 32'h0000_0080, 1);
    check("R8 disabled rd", rd_idx, 6);
    check("R8 disabled wr", wr_idx, 7);
    check("R8 disabled fill", fill_lvl, 1);

    push_n(63);
    check("R2 full fill", fill_lvl, 64);
    drive(1, 0, 32'h0, 1);
    check("R10 ovf pulse", ovf_pulse, 1);
    check("R10 wr held", wr_idx, 6);
    check("R10 fill held", fill_lvl, 64);
    drive(1, 0, 32'h0, 0);
    check("R10 ovf one cycle", ovf_pulse, 0);

    drive(1, 1, 32'h0000_0080, 1);
    check("R6 both at full fill", fill_lvl, 64);
    check("R10 no ovf with pop", ovf_pulse, 0);

    pop_n(56);
    check("R1 rd at 63", rd_idx, 63);
    check("R7 addr at 63", next_addr, 'h52B8);
    pop_n(1);
    check("R1 rd wraps", rd_idx, 0);

    soft_rst = 1'b1;
    drive(1, 1, 32'h0000_0080, 1);
    soft_rst = 1'b0;
    check("R9 soft rd", rd_idx, 0);
    check("R9 soft wr", wr_idx, 0);
    check("R9 soft fill", fill_lvl, 0);

    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r == 0) soft_rst = 1'b1;
      if (r == 1) hard_rst_n = 1'b0;
      drive($urandom_range(0, 9) != 0, $urandom_range(0, 2) == 0,
            $urandom, $urandom_range(0, 1) == 1);
      soft_rst = 1'b0;
      hard_rst_n = 1'b1;
    end

    @(negedge clk); #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule